// File: doc/BRIEF.md
# Local Interrupt Vector Table Dispatcher

This block keeps three local vector table entries, one for a timer source and one for each of two local interrupt pins (LINT0 and LINT1). It also keeps a base register that holds a base address, a global enable flag and a read-only bootstrap-processor flag. When one of the three sources reports an event, the block reads that source's entry and turns the event into one of two results. The first is a one-cycle request toward the core: system management (SMI), non-maskable (NMI) or external hard interrupt. The second is a fixed vector, which is posted into a pending register together with an edge or level tag.

The entries and the base register are written and read through a simple port. The port has a write enable, a 2-bit register select, 32-bit write data and combinational read data. The block also gives a combinational verdict on whether an interrupt from the legacy PIC is accepted. The reset values depend on the processor ID. Only processor 0 gets the bootstrap flag. Only processor 0 gets an unmasked LINT0 entry in external-interrupt mode, so that legacy PIC interrupts reach it from the start.

Top module: `lvt_dispatch`

## Requirements
- R1: Under synchronous active-low reset, the timer and LINT1 entries read 0x00010000. The LINT0 entry reads 0x00000700 when cpu_id is 0 and 0x00010000 otherwise.
- R2: The base register resets to 0xFEE00900 for cpu_id 0 and to 0xFEE00800 otherwise. Bits 31:12 hold the address, bit 11 is the enable and bit 8 is the bootstrap flag. A write changes only bits 31:11. Bit 8 keeps its reset value, and all other bits read 0.
- R3: Register select 0 is the timer entry, 1 is LINT0, 2 is LINT1 and 3 is the base register. An entry stores bit 16 (mask), bit 15 (level), bits 10:8 (mode) and bits 7:0 (vector), and its other bits read 0. Read data follows reg_addr combinationally, and a write is visible from the next cycle.
- R4: An event on a source whose entry has bit 16 set produces no pulse and changes neither pend_bits nor trig_bits.
- R5: An unmasked event raises exactly one pulse, lasting one cycle, in the cycle after the clock edge that sampled the event. Mode 010 raises smi_pulse, mode 100 raises nmi_pulse and mode 111 raises extint_pulse.
- R6: An unmasked event in mode 000 sets pend_bits[vector] from the cycle after the sampling edge. The bit stays set until reset.
- R7: A fixed delivery sets trig_bits[vector] to 1 only for LINT0 or LINT1 with entry bit 15 set, and to 0 otherwise. A timer delivery always writes 0, even when its bit 15 is set.
- R8: Modes 001, 011, 101 and 110 produce no pulse and no pending change.
- R9: Events on several sources in the same cycle are each delivered. When two or more of them post the same vector, the trigger tag comes from the last source in the order timer, LINT0, LINT1.
- R10: pic_accept is 1 when base bit 11 is clear or LINT0 bit 16 is clear, and 0 otherwise. It is combinational on the stored registers.
- R11: Timer events pass through the same mask and mode decoding as the LINT sources, including the SMI, NMI and external-interrupt modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_id | input | ID_W | Processor ID, sampled during reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| ev_timer | input | 1 | Timer expiry event |
| ev_lint0 | input | 1 | LINT0 event |
| ev_lint1 | input | 1 | LINT1 event |
| smi_pulse | output | 1 | System-management request pulse |
| nmi_pulse | output | 1 | Non-maskable request pulse |
| extint_pulse | output | 1 | External hard-interrupt request pulse |
| pend_bits | output | NUM_VEC | Pending fixed vectors |
| trig_bits | output | NUM_VEC | Trigger tag per vector, 1 = level |
| pic_accept | output | 1 | Legacy PIC interrupt accepted |

## Verification
The embedded assertions check the following on every cycle:
- Each decoder raises at most one kind of request, and a masked source raises none.
- The timer decoder never tags a fixed request as level.
- Pending bits never clear outside reset, and a new pending bit always follows a fixed request.
- Every request pulse follows an event.
- The bootstrap flag never changes.
- pic_accept agrees with the enable and LINT0 mask bits.

Only the bench scenarios can show the rest: the exact vector and tag that land for each source, the reset values for both kinds of processor ID, the effect of reserved modes, and which source's tag wins when several sources post the same vector in one cycle.

// File: rtl/lvt_pkg.sv
package lvt_pkg;

   localparam int MASK_BIT  = 16;
   localparam int LEVEL_BIT = 15;
   localparam int EN_BIT    = 11;

   localparam logic [2:0] DM_FIXED  = 3'b000;
   localparam logic [2:0] DM_SMI    = 3'b010;
   localparam logic [2:0] DM_NMI    = 3'b100;
   localparam logic [2:0] DM_EXTINT = 3'b111;

   localparam logic [1:0] SEL_TIMER = 2'd0;
   localparam logic [1:0] SEL_LINT0 = 2'd1;
   localparam logic [1:0] SEL_LINT1 = 2'd2;
   localparam logic [1:0] SEL_BASE  = 2'd3;

   localparam logic [19:0] BASE_ADDR_RST = 20'hFEE00;

   // stored fields of one vector table entry
   typedef struct packed {
      logic       mask;
      logic       level;
      logic [2:0] mode;
      logic [7:0] vec;
   } lvt_entry_t;

   localparam lvt_entry_t ENTRY_MASKED_RST = '{mask: 1'b1, level: 1'b0, mode: DM_FIXED,  vec: 8'h00};
   localparam lvt_entry_t ENTRY_BOOT_RST   = '{mask: 1'b0, level: 1'b0, mode: DM_EXTINT, vec: 8'h00};

   // decoded action of one source in one cycle
   typedef struct packed {
      logic       smi;
      logic       nmi;
      logic       ext;
      logic       fixed;
      logic       level;
      logic [7:0] vec;
   } lvt_act_t;

endpackage

// File: rtl/lvt_regs.sv
module lvt_regs
   import lvt_pkg::*;
#(
   parameter int ID_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [ID_W-1:0] cpu_id,
   input  logic            we,
   input  logic [1:0]      addr,
   input  logic [31:0]     wdata,
   output logic [31:0]     rdata,
   output lvt_entry_t      ent_timer,
   output lvt_entry_t      ent_lint0,
   output lvt_entry_t      ent_lint1,
   output logic            base_en
);

   initial begin
      assert (ID_W >= 1 && ID_W <= 32) else $error("lvt_regs: ID_W out of range");
   end

   lvt_entry_t  timer_q, lint0_q, lint1_q;
   logic [19:0] addr_q;
   logic        en_q, bsp_q;
   logic        boot_cpu;
   lvt_entry_t  wentry;

   assign boot_cpu = (cpu_id == '0);
   assign wentry   = '{mask:  wdata[MASK_BIT],
                       level: wdata[LEVEL_BIT],
                       mode:  wdata[10:8],
                       vec:   wdata[7:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         timer_q <= ENTRY_MASKED_RST;
         lint0_q <= boot_cpu ? ENTRY_BOOT_RST : ENTRY_MASKED_RST;
         lint1_q <= ENTRY_MASKED_RST;
         addr_q  <= BASE_ADDR_RST;
         en_q    <= 1'b1;
         bsp_q   <= boot_cpu;
      end else if (we) begin
         case (addr)
            SEL_TIMER: timer_q <= wentry;
            SEL_LINT0: lint0_q <= wentry;
            SEL_LINT1: lint1_q <= wentry;
            default: begin
               addr_q <= wdata[31:12];
               en_q   <= wdata[EN_BIT];
            end
         endcase
      end
   end

   function automatic logic [31:0] pack_entry(input lvt_entry_t e);
      return {15'b0, e.mask, e.level, 4'b0, e.mode, e.vec};
   endfunction

   always_comb begin
      case (addr)
         SEL_TIMER: rdata = pack_entry(timer_q);
         SEL_LINT0: rdata = pack_entry(lint0_q);
         SEL_LINT1: rdata = pack_entry(lint1_q);
         default:   rdata = {addr_q, en_q, 2'b00, bsp_q, 8'h00};
      endcase
   end

   assign ent_timer = timer_q;
   assign ent_lint0 = lint0_q;
   assign ent_lint1 = lint1_q;
   assign base_en   = en_q;

   // R2: bootstrap flag is fixed between resets
   a_r2_bsp_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(bsp_q));

endmodule

// File: rtl/lvt_decode.sv
module lvt_decode
   import lvt_pkg::*;
#(
   parameter bit LEVEL_OK = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev,
   input  lvt_entry_t entry,
   output lvt_act_t   act
);

   always_comb begin
      act = '0;
      if (ev && !entry.mask) begin
         case (entry.mode)
            DM_SMI:    act.smi = 1'b1;
            DM_NMI:    act.nmi = 1'b1;
            DM_EXTINT: act.ext = 1'b1;
            DM_FIXED: begin
               act.fixed = 1'b1;
               act.vec   = entry.vec;
               act.level = entry.level & LEVEL_OK;
            end
            default: act = '0;
         endcase
      end
   end

   // R4: a masked source yields no request of any kind
   a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      entry.mask |-> !(act.smi || act.nmi || act.ext || act.fixed));

   // R5: one request kind at most per source and cycle
   a_r5_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({act.smi, act.nmi, act.ext, act.fixed}));

   generate
      if (!LEVEL_OK) begin : g_edge_only
         // R7: an edge-only source never posts a level tag
         a_r7_timer_edge: assert property (@(posedge clk) disable iff (!rst_n)
            act.fixed |-> !act.level);
      end
   endgenerate

endmodule

// File: rtl/lvt_pending.sv
module lvt_pending #(
   parameter int NUM_VEC = 256,
   parameter int NUM_SRC = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SRC-1:0]       hit_v,
   input  logic [NUM_SRC-1:0]       lvl_v,
   input  logic [NUM_SRC-1:0][7:0]  vec_v,
   output logic [NUM_VEC-1:0]       pend_o,
   output logic [NUM_VEC-1:0]       trig_o
);

   initial begin
      assert (NUM_VEC >= 1 && NUM_VEC <= 256) else $error("lvt_pending: NUM_VEC out of range");
      assert (NUM_SRC >= 1) else $error("lvt_pending: NUM_SRC out of range");
   end

   for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
      logic [NUM_SRC-1:0] match;
      logic               tag;
      logic               p_q, t_q;

      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         assign match[s] = hit_v[s] && (vec_v[s] == 8'(i));
      end

      // later source in the fixed order wins the tag
      always_comb begin
         tag = 1'b0;
         for (int s = 0; s < NUM_SRC; s++) begin
            if (match[s]) tag = lvl_v[s];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            p_q <= 1'b0;
            t_q <= 1'b0;
         end else if (|match) begin
            p_q <= 1'b1;
            t_q <= tag;
         end
      end

      assign pend_o[i] = p_q;
      assign trig_o[i] = t_q;
   end

   // R6: pending bits are sticky until reset
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(pend_o) & ~pend_o) == '0));

   // R6: a newly pending vector needs a fixed request in the cycle before
   a_r6_new_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend_o & ~$past(pend_o))) |-> $past(|hit_v));

endmodule

// File: rtl/lvt_dispatch.sv
module lvt_dispatch
   import lvt_pkg::*;
#(
   parameter int ID_W    = 8,
   parameter int NUM_VEC = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ID_W-1:0]    cpu_id,
   input  logic               reg_we,
   input  logic [1:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic               ev_timer,
   input  logic               ev_lint0,
   input  logic               ev_lint1,
   output logic               smi_pulse,
   output logic               nmi_pulse,
   output logic               extint_pulse,
   output logic [NUM_VEC-1:0] pend_bits,
   output logic [NUM_VEC-1:0] trig_bits,
   output logic               pic_accept
);

   localparam int NUM_SRC = 3;

   lvt_entry_t ent [NUM_SRC];
   lvt_act_t   act [NUM_SRC];
   logic [NUM_SRC-1:0] ev_v;
   logic [NUM_SRC-1:0] hit_v, lvl_v, smi_v, nmi_v, ext_v;
   logic [NUM_SRC-1:0][7:0] vec_v;
   logic base_en;
   logic smi_q, nmi_q, ext_q;

   // source index order is the delivery order: timer, LINT0, LINT1
   assign ev_v = {ev_lint1, ev_lint0, ev_timer};

   lvt_regs #(.ID_W(ID_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_id    (cpu_id),
      .we        (reg_we),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .ent_timer (ent[0]),
      .ent_lint0 (ent[1]),
      .ent_lint1 (ent[2]),
      .base_en   (base_en)
   );

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      lvt_decode #(.LEVEL_OK(s != 0)) u_dec (
         .clk   (clk),
         .rst_n (rst_n),
         .ev    (ev_v[s]),
         .entry (ent[s]),
         .act   (act[s])
      );
      assign hit_v[s] = act[s].fixed;
      assign lvl_v[s] = act[s].level;
      assign vec_v[s] = act[s].vec;
      assign smi_v[s] = act[s].smi;
      assign nmi_v[s] = act[s].nmi;
      assign ext_v[s] = act[s].ext;
   end

   lvt_pending #(.NUM_VEC(NUM_VEC), .NUM_SRC(NUM_SRC)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_v  (hit_v),
      .lvl_v  (lvl_v),
      .vec_v  (vec_v),
      .pend_o (pend_bits),
      .trig_o (trig_bits)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smi_q <= 1'b0;
         nmi_q <= 1'b0;
         ext_q <= 1'b0;
      end else begin
         smi_q <= |smi_v;
         nmi_q <= |nmi_v;
         ext_q <= |ext_v;
      end
   end

   assign smi_pulse    = smi_q;
   assign nmi_pulse    = nmi_q;
   assign extint_pulse = ext_q;
   assign pic_accept   = !base_en || !ent[1].mask;

   // R5: every request pulse follows a sampled event
   a_r5_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (smi_pulse || nmi_pulse || extint_pulse) |-> $past(|ev_v));

   // R10: disabled base accepts legacy interrupts
   a_r10_pic_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !base_en |-> pic_accept);

   // R10: enabled base with masked LINT0 refuses them
   a_r10_pic_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (base_en && ent[1].mask) |-> !pic_accept);

endmodule

// File: tb/lvt_dispatch_test.sv
`timescale 1ns/1ps
module lvt_dispatch_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   cpu_id = 8'd0;
   logic         reg_we = 1'b0;
   logic [1:0]   reg_addr = 2'd0;
   logic [31:0]  reg_wdata = 32'd0;
   logic [31:0]  reg_rdata;
   logic         ev_timer = 1'b0, ev_lint0 = 1'b0, ev_lint1 = 1'b0;
   logic         smi_pulse, nmi_pulse, extint_pulse, pic_accept;
   logic [255:0] pend_bits, trig_bits;
   logic [255:0] exp_pend, exp_trig;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   lvt_dispatch uut (
      .clk(clk), .rst_n(rst_n), .cpu_id(cpu_id),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ev_timer(ev_timer), .ev_lint0(ev_lint0), .ev_lint1(ev_lint1),
      .smi_pulse(smi_pulse), .nmi_pulse(nmi_pulse), .extint_pulse(extint_pulse),
      .pend_bits(pend_bits), .trig_bits(trig_bits), .pic_accept(pic_accept)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_vec(input string req, input logic [255:0] act, input logic [255:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [7:0] id);
      @(negedge clk);
      rst_n  = 1'b0;
      cpu_id = id;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      exp_pend = '0;
      exp_trig = '0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
      reg_addr = a;
      #0.5;
      chk(req, reg_rdata, exp);
   endtask

   // raise events for one cycle; returns at the negedge where results are visible
   task automatic fire(input logic t, input logic l0, input logic l1);
      @(negedge clk);
      ev_timer = t; ev_lint0 = l0; ev_lint1 = l1;
      @(negedge clk);
      ev_timer = 1'b0; ev_lint0 = 1'b0; ev_lint1 = 1'b0;
   endtask

   task automatic chk_pulses(input string req, input logic [2:0] exp);
      chk(req, {29'b0, smi_pulse, nmi_pulse, extint_pulse}, {29'b0, exp});
   endtask

   task automatic after_idle(input string req);
      @(negedge clk);
      chk_pulses(req, 3'b000);
   endtask

   task automatic t_reset_boot;
      do_reset(8'd0);
      rd_chk("R1 timer reset", 2'd0, 32'h0001_0000);
      rd_chk("R1 lint0 reset id0", 2'd1, 32'h0000_0700);
      rd_chk("R1 lint1 reset", 2'd2, 32'h0001_0000);
      rd_chk("R2 base reset id0", 2'd3, 32'hFEE0_0900);
      chk_pulses("R5 pulses idle after reset", 3'b000);
      chk_vec("R6 pending reset", pend_bits, '0);
      chk("R10 pic accepted on id0", {31'b0, pic_accept}, 32'd1);
   endtask

   task automatic t_regs;
      wr(2'd0, 32'hFFFF_FFFF);
      rd_chk("R3 entry keeps only its fields", 2'd0, 32'h0001_87FF);
      wr(2'd0, 32'h0001_0000);
      wr(2'd3, 32'h1234_5FFF);
      rd_chk("R2 base write keeps bsp", 2'd3, 32'h1234_5900);
      wr(2'd3, 32'h0000_0000);
      rd_chk("R2 base cleared but bsp held", 2'd3, 32'h0000_0100);
      wr(2'd3, 32'hFEE0_0800);
   endtask

   task automatic t_pic;
      wr(2'd1, 32'h0001_0000);
      #0.5;
      chk("R10 masked lint0 with enable refuses", {31'b0, pic_accept}, 32'd0);
      wr(2'd3, 32'hFEE0_0000);
      #0.5;
      chk("R10 disabled base accepts", {31'b0, pic_accept}, 32'd1);
      wr(2'd3, 32'hFEE0_0800);
      wr(2'd1, 32'h0000_0700);
      #0.5;
      chk("R10 unmasked lint0 accepts", {31'b0, pic_accept}, 32'd1);
   endtask

   task automatic t_modes;
      wr(2'd1, 32'h0000_0200);
      fire(1'b0, 1'b1, 1'b0);
      chk_pulses("R5 lint0 smi", 3'b100);
      after_idle("R5 smi lasts one cycle");
      wr(2'd2, 32'h0000_0400);
      fire(1'b0, 1'b0, 1'b1);
      chk_pulses("R5 lint1 nmi", 3'b010);
      after_idle("R5 nmi lasts one cycle");
      wr(2'd0, 32'h0000_0700);
      fire(1'b1, 1'b0, 1'b0);
      chk_pulses("R11 timer extint", 3'b001);
      after_idle("R11 extint lasts one cycle");
      wr(2'd0, 32'h0000_0200);
      fire(1'b1, 1'b0, 1'b0);
      chk_pulses("R11 timer smi", 3'b100);
      chk_vec("R5 no pending from pulse modes", pend_bits, exp_pend);
   endtask

   task automatic t_masked;
      wr(2'd2, 32'h0001_0400);
      fire(1'b0, 1'b0, 1'b1);
      chk_pulses("R4 masked nmi quiet", 3'b000);
      wr(2'd2, 32'h0001_8033);
      fire(1'b0, 1'b0, 1'b1);
      chk_vec("R4 masked fixed pend", pend_bits, exp_pend);
      chk_vec("R4 masked fixed trig", trig_bits, exp_trig);
   endtask

   task automatic t_reserved;
      logic [31:0] codes [4] = '{32'h100, 32'h300, 32'h500, 32'h600};
      for (int k = 0; k < 4; k++) begin
         wr(2'd0, codes[k] | 32'h21);
         fire(1'b1, 1'b0, 1'b0);
         chk_pulses("R8 reserved mode quiet", 3'b000);
         chk_vec("R8 reserved mode no pending", pend_bits, exp_pend);
      end
   endtask

   task automatic t_fixed;
      wr(2'd1, 32'h0000_0041);
      fire(1'b0, 1'b1, 1'b0);
      exp_pend[8'h41] = 1'b1;
      chk_vec("R6 lint0 fixed pend", pend_bits, exp_pend);
      chk_vec("R7 lint0 edge tag", trig_bits, exp_trig);
      repeat (3) @(negedge clk);
      chk_vec("R6 pending stays set", pend_bits, exp_pend);
      wr(2'd2, 32'h0000_8052);
      fire(1'b0, 1'b0, 1'b1);
      exp_pend[8'h52] = 1'b1; exp_trig[8'h52] = 1'b1;
      chk_vec("R7 lint1 level tag", trig_bits, exp_trig);
      wr(2'd0, 32'h0000_8060);
      fire(1'b1, 1'b0, 1'b0);
      exp_pend[8'h60] = 1'b1;
      chk_vec("R11 timer fixed pend", pend_bits, exp_pend);
      chk_vec("R7 timer ignores level bit", trig_bits, exp_trig);
   endtask

   task automatic t_simul;
      wr(2'd0, 32'h0000_0200);
      wr(2'd1, 32'h0000_0400);
      wr(2'd2, 32'h0000_0070);
      fire(1'b1, 1'b1, 1'b1);
      exp_pend[8'h70] = 1'b1;
      chk_pulses("R9 simultaneous smi and nmi", 3'b110);
      chk_vec("R9 simultaneous fixed", pend_bits, exp_pend);
      wr(2'd0, 32'h0000_0080);
      wr(2'd1, 32'h0000_8080);
      wr(2'd2, 32'h0000_0080);
      fire(1'b1, 1'b1, 1'b1);
      exp_pend[8'h80] = 1'b1; exp_trig[8'h80] = 1'b0;
      chk_vec("R9 lint1 tag wins", trig_bits, exp_trig);
      wr(2'd0, 32'h0000_0090);
      wr(2'd1, 32'h0000_8090);
      wr(2'd2, 32'h0001_0090);
      fire(1'b1, 1'b1, 1'b1);
      exp_pend[8'h90] = 1'b1; exp_trig[8'h90] = 1'b1;
      chk_vec("R9 lint0 tag over timer", trig_bits, exp_trig);
      chk_vec("R9 pend after same vector", pend_bits, exp_pend);
   endtask

   task automatic t_reset_other;
      do_reset(8'd3);
      rd_chk("R1 lint0 reset nonzero id", 2'd1, 32'h0001_0000);
      rd_chk("R2 base reset nonzero id", 2'd3, 32'hFEE0_0800);
      chk_vec("R6 pending cleared by reset", pend_bits, '0);
      chk_vec("R7 tags cleared by reset", trig_bits, '0);
      chk("R10 refused on nonzero id", {31'b0, pic_accept}, 32'd0);
   endtask

   initial begin
      #(4 * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      exp_pend = '0;
      exp_trig = '0;
      t_reset_boot();
      t_regs();
      t_pic();
      t_modes();
      t_masked();
      t_reserved();
      t_fixed();
      t_simul();
      t_reset_other();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule